// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block holds the forwarding select logic for a five-stage in-order pipeline. Its inputs are the register fields and instruction classes of five places in the pipe: the decode slot, execute (slot 1), memory (slot 2), writeback (slot 3) and a one-deep preserved slot behind writeback (slot 4). Its outputs are multiplexer selects for the datapath.

Two bypass points are served. In decode, each source operand latch can take the register file, the execute result register, its memory-stage copy, or the extended load data. In execute, each operand input can take the operand latch, the execute result register, the load data register, or its preserved copy. The first execute operand feeds both the ALU and the memory address adder. The second feeds the ALU and the store-data path.

A separate select steers the memory write port to the load data register. This covers a store whose data comes from the load directly ahead of it. In every case the newest producer in the pipe wins. Stall generation and branch resolution are done elsewhere. All selects are registered. The selects are computed from the stage contents presented in one cycle and appear after the next clock edge.

Top module: `fwd_bypass_sel`

## Requirements
- R1: Class codes are NOP=0, ALU register form=1, ALU immediate form=2, LOAD=3, STORE=4, BRANCH=5, JUMP=6, LINK=7, move-from-special=8, move-to-special=9. Only ALU (both forms), LOAD, LINK and move-from-special have a destination. A LINK always writes the highest register (all ones), whatever its destination field holds.
- R2: Decode select codes are register file=0, execute result=1, memory-stage copy=2, load data=3. A used decode source equal to the destination of a non-load producer in slot 2 selects 1. If it matches a LOAD in slot 2, it selects 0 and older slots are not considered. Otherwise a match with a non-load producer in slot 3 selects 2. With no match the select is 0.
- R3: A used decode source whose newest match is a LOAD in slot 3 selects 3.
- R4: Execute select codes are latch=0, execute result=1, load data=2, preserved load data=3. A used execute source matching a non-load producer in slot 2 selects 1. A match with a LOAD in slot 2 selects 0 and blocks older slots.
- R5: With no slot 2 match, a used execute source matching a LOAD in slot 3 selects 2. A match with a non-load producer in slot 3 selects 0 and blocks slot 4.
- R6: With no slot 2 or slot 3 match, a used execute source matching a LOAD in slot 4 selects 3. A non-load producer in slot 4 is ignored, and the select is then 0.
- R7: Operand use is fixed per class. ALU register form and STORE use both sources. ALU immediate form, LOAD and move-to-special use the first source only. An unused source always selects 0.
- R8: BRANCH, JUMP, LINK, NOP and move-from-special in decode or execute get select 0 on both operands, whatever their fields hold.
- R9: Register 0 never produces a match, neither as a source nor as a destination.
- R10: The write-port select is 1 exactly when slot 2 is a STORE, slot 3 is a LOAD with a nonzero destination, and that destination equals the store's second source.
- R11: Selects appear one clock after their inputs. A synchronous active-high reset forces every select to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_src1 | input | AW | Decode instruction first source |
| id_src2 | input | AW | Decode instruction second source |
| id_cls | input | 4 | Decode instruction class |
| ex_src1 | input | AW | Slot 1 first source |
| ex_src2 | input | AW | Slot 1 second source |
| ex_cls | input | 4 | Slot 1 class |
| mem_dst | input | AW | Slot 2 destination field |
| mem_src2 | input | AW | Slot 2 second source (store data register) |
| mem_cls | input | 4 | Slot 2 class |
| wb_dst | input | AW | Slot 3 destination field |
| wb_cls | input | 4 | Slot 3 class |
| hold_dst | input | AW | Slot 4 destination field |
| hold_cls | input | 4 | Slot 4 class |
| dec_sel_a | output | 2 | Decode first operand latch select |
| dec_sel_b | output | 2 | Decode second operand latch select |
| ex_sel_a | output | 2 | Execute first operand select (ALU and address) |
| ex_sel_b | output | 2 | Execute second operand select (ALU and store data) |
| wport_sel | output | 1 | Memory write port takes load data |

## Verification
The bench builds the block with AW=5, which gives 32 registers. At that size register 0 and the all-ones LINK register are both reachable, and the directed table can use distinct register numbers per slot. The random phase draws destinations and sources from registers 0 to 7 only. This makes multi-slot matches, and ties between slot 2, slot 3 and slot 4, frequent enough to exercise every priority branch and the register 0 exclusion.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Instruction class codes (R1)
  localparam logic [3:0] CLS_NOP    = 4'd0;
  localparam logic [3:0] CLS_ALU_R  = 4'd1;
  localparam logic [3:0] CLS_ALU_I  = 4'd2;
  localparam logic [3:0] CLS_LOAD   = 4'd3;
  localparam logic [3:0] CLS_STORE  = 4'd4;
  localparam logic [3:0] CLS_BRANCH = 4'd5;
  localparam logic [3:0] CLS_JUMP   = 4'd6;
  localparam logic [3:0] CLS_LINK   = 4'd7;
  localparam logic [3:0] CLS_MOVF   = 4'd8;
  localparam logic [3:0] CLS_MOVT   = 4'd9;

  // Decode latch sources (R2, R3)
  localparam logic [1:0] DSEL_RF   = 2'd0;
  localparam logic [1:0] DSEL_EXR  = 2'd1;
  localparam logic [1:0] DSEL_MEMR = 2'd2;
  localparam logic [1:0] DSEL_LDX  = 2'd3;

  // Execute input sources (R4, R5, R6)
  localparam logic [1:0] ESEL_LATCH = 2'd0;
  localparam logic [1:0] ESEL_EXR   = 2'd1;
  localparam logic [1:0] ESEL_LDR   = 2'd2;
  localparam logic [1:0] ESEL_LDP   = 2'd3;

  function automatic logic has_dest(input logic [3:0] c);
    return (c == CLS_ALU_R) || (c == CLS_ALU_I) || (c == CLS_LOAD) ||
           (c == CLS_LINK)  || (c == CLS_MOVF);
  endfunction

  function automatic logic reads_first(input logic [3:0] c);
    return (c == CLS_ALU_R) || (c == CLS_ALU_I) || (c == CLS_LOAD) ||
           (c == CLS_STORE) || (c == CLS_MOVT);
  endfunction

  function automatic logic reads_second(input logic [3:0] c);
    return (c == CLS_ALU_R) || (c == CLS_STORE);
  endfunction

endpackage

// File: rtl/fwd_slot_dec.sv
module fwd_slot_dec
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [3:0]    cls,
  input  logic [AW-1:0] dst,
  output logic          live,
  output logic [AW-1:0] eff_dst,
  output logic          is_ld
);
  // LINK writes the top register whatever its field holds
  always_comb begin
    eff_dst = (cls == CLS_LINK) ? {AW{1'b1}} : dst;
    live    = has_dest(cls) && (eff_dst != '0);
    is_ld   = (cls == CLS_LOAD);
  end
endmodule

// File: rtl/fwd_dec_pick.sv
module fwd_dec_pick
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          used,
  input  logic          live2,
  input  logic [AW-1:0] dst2,
  input  logic          ld2,
  input  logic          live3,
  input  logic [AW-1:0] dst3,
  input  logic          ld3,
  output logic [1:0]    sel
);
  logic hit2, hit3;

  always_comb begin
    hit2 = used && live2 && (src == dst2);
    hit3 = used && live3 && (src == dst3);
    if (hit2)      sel = ld2 ? DSEL_RF : DSEL_EXR;
    else if (hit3) sel = ld3 ? DSEL_LDX : DSEL_MEMR;
    else           sel = DSEL_RF;
  end
endmodule

// File: rtl/fwd_ex_pick.sv
module fwd_ex_pick
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          used,
  input  logic          live2,
  input  logic [AW-1:0] dst2,
  input  logic          ld2,
  input  logic          live3,
  input  logic [AW-1:0] dst3,
  input  logic          ld3,
  input  logic          live4,
  input  logic [AW-1:0] dst4,
  input  logic          ld4,
  output logic [1:0]    sel
);
  logic hit2, hit3, hit4;

  always_comb begin
    hit2 = used && live2 && (src == dst2);
    hit3 = used && live3 && (src == dst3);
    hit4 = used && live4 && (src == dst4);
    if (hit2)             sel = ld2 ? ESEL_LATCH : ESEL_EXR;
    else if (hit3)        sel = ld3 ? ESEL_LDR : ESEL_LATCH;
    else if (hit4 && ld4) sel = ESEL_LDP;
    else                  sel = ESEL_LATCH;
  end
endmodule

// File: rtl/fwd_bypass_sel.sv
module fwd_bypass_sel
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] id_src1,
  input  logic [AW-1:0] id_src2,
  input  logic [3:0]    id_cls,
  input  logic [AW-1:0] ex_src1,
  input  logic [AW-1:0] ex_src2,
  input  logic [3:0]    ex_cls,
  input  logic [AW-1:0] mem_dst,
  input  logic [AW-1:0] mem_src2,
  input  logic [3:0]    mem_cls,
  input  logic [AW-1:0] wb_dst,
  input  logic [3:0]    wb_cls,
  input  logic [AW-1:0] hold_dst,
  input  logic [3:0]    hold_cls,
  output logic [1:0]    dec_sel_a,
  output logic [1:0]    dec_sel_b,
  output logic [1:0]    ex_sel_a,
  output logic [1:0]    ex_sel_b,
  output logic          wport_sel
);
  localparam int NSLOT = 3;   // slots 2, 3, 4 carry producers
  localparam int NOPS  = 2;

  logic [3:0]    s_cls [NSLOT];
  logic [AW-1:0] s_dst [NSLOT];
  logic          s_live[NSLOT];
  logic [AW-1:0] s_eff [NSLOT];
  logic          s_ld  [NSLOT];

  always_comb begin
    s_cls[0] = mem_cls;  s_dst[0] = mem_dst;
    s_cls[1] = wb_cls;   s_dst[1] = wb_dst;
    s_cls[2] = hold_cls; s_dst[2] = hold_dst;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    fwd_slot_dec #(.AW(AW)) u_slot (
      .cls(s_cls[g]), .dst(s_dst[g]),
      .live(s_live[g]), .eff_dst(s_eff[g]), .is_ld(s_ld[g])
    );
  end

  logic [AW-1:0] id_src [NOPS];
  logic [AW-1:0] ex_src [NOPS];
  logic          id_use [NOPS];
  logic          ex_use [NOPS];
  logic [1:0]    dsel_n [NOPS];
  logic [1:0]    esel_n [NOPS];

  always_comb begin
    id_src[0] = id_src1; id_src[1] = id_src2;
    ex_src[0] = ex_src1; ex_src[1] = ex_src2;
    id_use[0] = reads_first(id_cls);  id_use[1] = reads_second(id_cls);
    ex_use[0] = reads_first(ex_cls);  ex_use[1] = reads_second(ex_cls);
  end

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    fwd_dec_pick #(.AW(AW)) u_dec (
      .src(id_src[k]), .used(id_use[k]),
      .live2(s_live[0]), .dst2(s_eff[0]), .ld2(s_ld[0]),
      .live3(s_live[1]), .dst3(s_eff[1]), .ld3(s_ld[1]),
      .sel(dsel_n[k])
    );
    fwd_ex_pick #(.AW(AW)) u_ex (
      .src(ex_src[k]), .used(ex_use[k]),
      .live2(s_live[0]), .dst2(s_eff[0]), .ld2(s_ld[0]),
      .live3(s_live[1]), .dst3(s_eff[1]), .ld3(s_ld[1]),
      .live4(s_live[2]), .dst4(s_eff[2]), .ld4(s_ld[2]),
      .sel(esel_n[k])
    );
  end

  logic wport_n;
  always_comb begin
    wport_n = (mem_cls == CLS_STORE) && s_live[1] && s_ld[1] &&
              (mem_src2 == s_eff[1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_sel_a <= DSEL_RF;
      dec_sel_b <= DSEL_RF;
      ex_sel_a  <= ESEL_LATCH;
      ex_sel_b  <= ESEL_LATCH;
      wport_sel <= 1'b0;
    end else begin
      dec_sel_a <= dsel_n[0];
      dec_sel_b <= dsel_n[1];
      ex_sel_a  <= esel_n[0];
      ex_sel_b  <= esel_n[1];
      wport_sel <= wport_n;
    end
  end

  // R11
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |->
    (dec_sel_a == 2'd0 && dec_sel_b == 2'd0 && ex_sel_a == 2'd0 &&
     ex_sel_b == 2'd0 && !wport_sel));

  // R2
  dec_exr_src_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_sel_a == DSEL_EXR) |-> ($past(mem_cls) != CLS_LOAD && has_dest($past(mem_cls))));

  // R9
  zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_sel_a != DSEL_RF || ex_sel_a != ESEL_LATCH) |->
      ($past(id_src1) != '0 || $past(ex_src1) != '0));

  // R8
  branch_nofwd_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(id_cls) == CLS_BRANCH || $past(id_cls) == CLS_JUMP) |->
      (dec_sel_a == DSEL_RF && dec_sel_b == DSEL_RF));

  // R7
  imm_second_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ex_cls) == CLS_ALU_I) |-> (ex_sel_b == ESEL_LATCH));

  // R6
  held_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_sel_a == ESEL_LDP) |-> ($past(hold_cls) == CLS_LOAD));

  // R10
  wport_cls_chk: assert property (@(posedge clk) disable iff (rst)
    wport_sel |-> ($past(mem_cls) == CLS_STORE && $past(wb_cls) == CLS_LOAD));

endmodule

// File: tb/fwd_bypass_sel_test.sv
module fwd_bypass_sel_test;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [AW-1:0] id_src1, id_src2, ex_src1, ex_src2, mem_dst, mem_src2, wb_dst, hold_dst;
  logic [3:0]    id_cls, ex_cls, mem_cls, wb_cls, hold_cls;
  logic [1:0]    dec_sel_a, dec_sel_b, ex_sel_a, ex_sel_b;
  logic          wport_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fwd_bypass_sel #(.AW(AW)) uut (
    .clk(clk), .rst(rst),
    .id_src1(id_src1), .id_src2(id_src2), .id_cls(id_cls),
    .ex_src1(ex_src1), .ex_src2(ex_src2), .ex_cls(ex_cls),
    .mem_dst(mem_dst), .mem_src2(mem_src2), .mem_cls(mem_cls),
    .wb_dst(wb_dst), .wb_cls(wb_cls),
    .hold_dst(hold_dst), .hold_cls(hold_cls),
    .dec_sel_a(dec_sel_a), .dec_sel_b(dec_sel_b),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .wport_sel(wport_sel)
  );

  typedef struct packed {
    logic [4:0] s1; logic [4:0] s2; logic [3:0] c;
    logic [4:0] e1; logic [4:0] e2; logic [3:0] ec;
    logic [4:0] d2; logic [4:0] m2; logic [3:0] c2;
    logic [4:0] d3; logic [3:0] c3;
    logic [4:0] d4; logic [3:0] c4;
    logic [1:0] da; logic [1:0] db; logic [1:0] ea; logic [1:0] eb; logic wp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3,4,1,    0,0,0,    3,0,1,   4,1,  0,0,  1,2,0,0,0},  // R2 slot2 then slot3 ALU
    '{5,5,1,    6,7,1,    5,0,1,   5,3,  7,3,  1,1,0,3,0},  // R2 newest wins, R6 held load
    '{8,8,2,    8,8,2,    0,0,0,   8,3,  0,0,  3,0,2,0,0},  // R3 R5 R7 immediate form
    '{0,0,1,    0,0,1,    0,0,1,   0,3,  0,3,  0,0,0,0,0},  // R9 register 0
    '{2,2,5,    2,2,6,    2,0,1,   2,1,  2,3,  0,0,0,0,0},  // R8 branch and jump
    '{31,1,1,   31,31,4,  0,0,7,   0,0,  0,0,  1,0,1,1,0},  // R1 link top register, R4
    '{12,13,4,  12,12,4,  12,0,3,  12,3, 0,0,  0,0,0,0,0},  // R2 R4 load in slot 2 blocks
    '{0,0,0,    14,0,9,   0,14,4,  14,3, 0,0,  0,0,2,0,1},  // R10 port, R7 move-to-special
    '{16,16,8,  16,15,1,  0,15,4,  16,3, 15,3, 0,0,2,3,0},  // R10 mismatch, R6, R8 movf
    '{20,22,1,  20,21,1,  22,0,5,  20,8, 20,3, 2,0,0,0,0},  // R5 non-load slot3 blocks slot4
    '{26,25,1,  25,0,3,   26,0,2,  0,0,  25,1, 1,0,0,0,0},  // R6 non-load slot4 ignored
    '{18,17,9,  17,17,1,  17,0,1,  18,3, 0,0,  3,0,1,1,0}   // R4 both operands, R3 R7
  };

  task automatic drive(input vec_t v);
    id_src1 = v.s1; id_src2 = v.s2; id_cls = v.c;
    ex_src1 = v.e1; ex_src2 = v.e2; ex_cls = v.ec;
    mem_dst = v.d2; mem_src2 = v.m2; mem_cls = v.c2;
    wb_dst = v.d3; wb_cls = v.c3;
    hold_dst = v.d4; hold_cls = v.c4;
  endtask

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic chk_all(input string tag, input vec_t v);
    chk({tag, " R2 R3 dec a"}, dec_sel_a, v.da);
    chk({tag, " R2 R3 dec b"}, dec_sel_b, v.db);
    chk({tag, " R4 R5 R6 ex a"}, ex_sel_a, v.ea);
    chk({tag, " R4 R5 R6 ex b"}, ex_sel_b, v.eb);
    chk({tag, " R10 wport"}, wport_sel, v.wp);
  endtask

  // Reference written from the requirements
  function automatic logic ref_prod(input logic [3:0] c);
    return c == 1 || c == 2 || c == 3 || c == 7 || c == 8;
  endfunction
  function automatic logic [4:0] ref_dst(input logic [3:0] c, input logic [4:0] d);
    return (c == 7) ? 5'd31 : d;
  endfunction
  function automatic logic ref_match(input logic [4:0] s, input logic [3:0] c, input logic [4:0] d);
    return ref_prod(c) && ref_dst(c, d) != 0 && s == ref_dst(c, d);
  endfunction
  function automatic logic ref_use(input logic [3:0] c, input int n);
    if (n == 1) return c == 1 || c == 2 || c == 3 || c == 4 || c == 9;
    return c == 1 || c == 4;
  endfunction

  function automatic vec_t ref_model(input vec_t v);
    vec_t r = v;
    logic [4:0] src;
    for (int n = 1; n <= 2; n++) begin
      logic [1:0] d, e;
      src = (n == 1) ? v.s1 : v.s2;
      d = 0;
      if (ref_use(v.c, n)) begin
        if (ref_match(src, v.c2, v.d2)) d = (v.c2 == 3) ? 2'd0 : 2'd1;
        else if (ref_match(src, v.c3, v.d3)) d = (v.c3 == 3) ? 2'd3 : 2'd2;
      end
      src = (n == 1) ? v.e1 : v.e2;
      e = 0;
      if (ref_use(v.ec, n)) begin
        if (ref_match(src, v.c2, v.d2)) e = (v.c2 == 3) ? 2'd0 : 2'd1;
        else if (ref_match(src, v.c3, v.d3)) e = (v.c3 == 3) ? 2'd2 : 2'd0;
        else if (ref_match(src, v.c4, v.d4) && v.c4 == 3) e = 2'd3;
      end
      if (n == 1) begin r.da = d; r.ea = e; end
      else begin r.db = d; r.eb = e; end
    end
    r.wp = (v.c2 == 4) && (v.c3 == 3) && (v.d3 != 0) && (v.m2 == v.d3);
    return r;
  endfunction

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t zero_v;
    zero_v = '0;
    // R11: reset clears selects even with matching inputs present
    drive(VEC[0]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_all("R11 reset", zero_v);
    rst = 1'b0;
    // R11: no change before the clock edge
    #1;
    chk_all("R11 before edge", zero_v);
    @(posedge clk); @(negedge clk);
    chk_all("R11 one cycle", VEC[0]);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk); @(negedge clk);
      chk_all($sformatf("vec%0d", i), VEC[i]);
    end

    // Random stage contents against the priority model (R1 through R10 paths)
    for (int i = 0; i < 400; i++) begin
      vec_t v;
      v.s1 = 5'($urandom_range(0, 7)); v.s2 = 5'($urandom_range(0, 7));
      v.c  = 4'($urandom_range(0, 9));
      v.e1 = 5'($urandom_range(0, 7)); v.e2 = 5'($urandom_range(0, 7));
      v.ec = 4'($urandom_range(0, 9));
      v.d2 = 5'($urandom_range(0, 7)); v.m2 = 5'($urandom_range(0, 7));
      v.c2 = 4'($urandom_range(0, 9));
      v.d3 = 5'($urandom_range(0, 7)); v.c3 = 4'($urandom_range(0, 9));
      v.d4 = 5'($urandom_range(0, 7)); v.c4 = 4'($urandom_range(0, 9));
      v = ref_model(v);
      drive(v);
      @(posedge clk); @(negedge clk);
      chk_all("random", v);
    end

    // R11: reset in mid-run clears selects
    drive(VEC[11]);
    @(posedge clk); @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_all("R11 mid reset", zero_v);
    rst = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule